// File: doc/BRIEF.md
# Increment/Decrement Pulse Adjuster

This block turns a stream of rate ticks into an output pulse train whose phase can be nudged one tick slot at a time. With no correction requests, it emits a pulse on every second tick, so the pulse rate is half the tick rate. A carry request adds one pulse: a tick that would otherwise be silent emits a pulse. A borrow request removes one pulse: a tick that would otherwise emit is held silent. In a digital phase-locked loop, an up/down loop counter issues these requests, and a divide-by-N counter downstream of this block divides the corrected pulse train.

Carry and borrow requests arrive as levels that may be launched from another clock domain. Each level passes through a parameterised synchroniser. Its rising edge is then turned into a single event. At most one event of each kind is held pending until its tick slot comes around. When a carry and a borrow are live at the same time, they cancel each other.

Each tick, and so each output pulse, lasts one system-clock cycle. Ticks must be at least two cycles apart, so that each pulse is seen as a separate pulse.

Top module: `incdec_pulse_adjuster`

## Requirements
- R1: While `rst_i` is high at a clock edge, the next cycle shows `pulse_o` low and no pending carry or borrow. After reset the block starts in the silent phase, so the first tick emits no pulse.
- R2: With nothing pending, ticks alternate between silent and emitting. An emitting tick drives `pulse_o` high for exactly the one cycle that follows the tick's clock edge.
- R3: A low-to-high change on `carry_req_i` or `borrow_req_i` becomes exactly one event. The event can first act at the clock edge `SYNC_STAGES` edges after the edge that first samples the high level. A level held high for any length of time is a single event.
- R4: A pending carry acts at the next silent tick. That tick emits a pulse and the phase does not advance, so the following tick is silent again.
- R5: A pending borrow acts at the next emitting tick. That tick is suppressed and the phase does not advance, so the following tick emits.
- R6: Whenever a carry and a borrow are live in the same cycle (pending or just arriving), both are discarded, and the tick pattern continues unchanged.
- R7: A second request of the same kind that arrives while one is already pending merges into the pending one and adds no further correction.
- R8: Without a tick, `pulse_o` stays low and the phase does not move. Pending events wait for a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle rate tick that paces the output |
| carry_req_i | input | 1 | Carry request level; a rising edge asks for one added pulse |
| borrow_req_i | input | 1 | Borrow request level; a rising edge asks for one deleted pulse |
| pulse_o | output | 1 | Corrected output pulse train, one cycle per pulse |

## Verification
A carry and a borrow can be live in the same cycle. The bench provokes this in two ways: by raising both request levels on the same cycle, and by raising a borrow while a carry is already waiting between ticks. In both cases it judges the outcome by the ticks that follow, which must keep exactly the nominal silent/emitting pattern. A tick can also land on the same edge at which a fresh request first becomes usable. The bench places ticks just before and exactly at that edge, and checks that the correction is applied at the first slot of the right kind at or after that edge.

// File: rtl/incdec_adj_pkg.sv
package incdec_adj_pkg;

  // Result of one phase decision for the current cycle.
  typedef struct packed {
    logic take_carry;   // carry consumed at this tick
    logic take_borrow;  // borrow consumed at this tick
    logic emit;         // a pulse leaves on this tick
    logic armed_nxt;    // phase after this cycle
  } phase_step_t;

  // Phase rule: an armed tick emits, a disarmed tick is silent.
  // A carry fills a silent slot and a borrow empties an emitting slot.
  // In both cases the phase is held instead of advancing.
  function automatic phase_step_t phase_step(input logic armed,
                                             input logic tick,
                                             input logic carry_live,
                                             input logic borrow_live);
    phase_step_t r;
    r.take_carry  = tick & carry_live & ~armed;
    r.take_borrow = tick & borrow_live & armed;
    r.emit        = tick & (armed ? ~r.take_borrow : r.take_carry);
    r.armed_nxt   = (~tick | r.take_carry | r.take_borrow) ? armed : ~armed;
    return r;
  endfunction

  // Opposing requests in the same cycle annihilate.
  function automatic logic both_live(input logic c, input logic b);
    return c & b;
  endfunction

endpackage

// File: rtl/incdec_req_sync.sv
module incdec_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic rise_o
);
  logic lvl;
  logic prev_q;

  generate
    if (STAGES == 0) begin : g_direct
      assign lvl = req_i;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          sync_q <= '0;
        end else begin
          sync_q[0] <= req_i;
          for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
        end
      end
      assign lvl = sync_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= lvl;
  end

  assign rise_o = lvl & ~prev_q;

  // R3: one event per rising edge, never on two cycles in a row
  a_r3_single_rise: assert property (@(posedge clk_i) disable iff (rst_i)
    rise_o |=> !rise_o);

endmodule

// File: rtl/incdec_pending.sv
module incdec_pending
  import incdec_adj_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic carry_rise_i,
  input  logic borrow_rise_i,
  input  logic take_carry_i,
  input  logic take_borrow_i,
  output logic carry_eff_o,
  output logic borrow_eff_o
);
  logic carry_q, borrow_q;
  logic carry_live, borrow_live, clash;

  // A new request merges into a pending one of the same kind.
  assign carry_live  = carry_q  | carry_rise_i;
  assign borrow_live = borrow_q | borrow_rise_i;
  assign clash       = both_live(carry_live, borrow_live);

  assign carry_eff_o  = carry_live  & ~clash;
  assign borrow_eff_o = borrow_live & ~clash;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      carry_q  <= carry_eff_o  & ~take_carry_i;
      borrow_q <= borrow_eff_o & ~take_borrow_i;
    end
  end

  // R1: reset leaves nothing pending
  a_r1_pending_reset: assert property (@(posedge clk_i)
    rst_i |=> (!carry_q && !borrow_q));

  // R6: opposing live requests are both dropped
  a_r6_cancel: assert property (@(posedge clk_i) disable iff (rst_i)
    (carry_live && borrow_live) |=> (!carry_q && !borrow_q));

  // R6: the store never holds a carry and a borrow together
  a_r6_never_both: assert property (@(posedge clk_i) disable iff (rst_i)
    !(carry_q && borrow_q));

  // R7: a merged request leaves a single pending carry until used
  a_r7_merge_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (carry_q && carry_rise_i && !borrow_live && !take_carry_i) |=> carry_q);

endmodule

// File: rtl/incdec_phase.sv
module incdec_phase
  import incdec_adj_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic carry_eff_i,
  input  logic borrow_eff_i,
  output logic take_carry_o,
  output logic take_borrow_o,
  output logic pulse_o
);
  logic        armed_q;
  logic        pulse_q;
  phase_step_t step;

  always_comb step = phase_step(armed_q, tick_i, carry_eff_i, borrow_eff_i);

  assign take_carry_o  = step.take_carry;
  assign take_borrow_o = step.take_borrow;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= step.armed_nxt;
      pulse_q <= step.emit;
    end
  end

  assign pulse_o = pulse_q;

  // R1: reset drives the output low and the phase silent
  a_r1_reset_low: assert property (@(posedge clk_i)
    rst_i |=> (!pulse_o && !armed_q));

  // R2: a plain tick advances the phase
  a_r2_alternate: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !carry_eff_i && !borrow_eff_i) |=> (armed_q != $past(armed_q)));

  // R4: a carry at a silent tick yields a pulse and holds the phase
  a_r4_carry_adds: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && carry_eff_i && !armed_q) |=> (pulse_o && !armed_q));

  // R5: a borrow at an emitting tick suppresses it and holds the phase
  a_r5_borrow_drops: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && borrow_eff_i && armed_q) |=> (!pulse_o && armed_q));

  // R8: without a tick nothing leaves and the phase is frozen
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_i |=> (!pulse_o && $stable(armed_q)));

endmodule

// File: rtl/incdec_pulse_adjuster.sv
module incdec_pulse_adjuster #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic carry_req_i,
  input  logic borrow_req_i,
  output logic pulse_o
);
  localparam int NUM_REQ = 2;
  localparam int IDX_CARRY = 0;
  localparam int IDX_BORROW = 1;

  logic [NUM_REQ-1:0] req_vec;
  logic [NUM_REQ-1:0] rise_vec;
  logic carry_eff, borrow_eff;
  logic take_carry, take_borrow;

  assign req_vec[IDX_CARRY]  = carry_req_i;
  assign req_vec[IDX_BORROW] = borrow_req_i;

  generate
    for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
      incdec_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (req_vec[g]),
        .rise_o (rise_vec[g])
      );
    end
  endgenerate

  incdec_pending u_pending (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .carry_rise_i  (rise_vec[IDX_CARRY]),
    .borrow_rise_i (rise_vec[IDX_BORROW]),
    .take_carry_i  (take_carry),
    .take_borrow_i (take_borrow),
    .carry_eff_o   (carry_eff),
    .borrow_eff_o  (borrow_eff)
  );

  incdec_phase u_phase (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tick_i        (tick_i),
    .carry_eff_i   (carry_eff),
    .borrow_eff_i  (borrow_eff),
    .take_carry_o  (take_carry),
    .take_borrow_o (take_borrow),
    .pulse_o       (pulse_o)
  );

  // R6: a consumed correction is never of both kinds at once
  a_r6_single_take: assert property (@(posedge clk_i) disable iff (rst_i)
    !(take_carry && take_borrow));

endmodule

// File: tb/incdec_pulse_adjuster_bench.sv
module incdec_pulse_adjuster_bench;
  localparam int S = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, creq = 1'b0, breq = 1'b0;
  logic pulse;

  incdec_pulse_adjuster #(.SYNC_STAGES(S)) u_incdec_pulse_adjuster (
    .clk_i(clk), .rst_i(rst), .tick_i(tick),
    .carry_req_i(creq), .borrow_req_i(breq), .pulse_o(pulse));

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference
  bit qc[$], qb[$];
  bit m_cp, m_bp, m_phase_on, m_pulse;
  int tick_idx;
  bit pulse_at[32];

  task automatic model_edge();
    bit rc, rb, cl, bl, used;
    qc.push_front(rst ? 1'b0 : creq); void'(qc.pop_back());
    qb.push_front(rst ? 1'b0 : breq); void'(qb.pop_back());
    if (rst) begin
      m_cp = 0; m_bp = 0; m_phase_on = 0; m_pulse = 0;
      return;
    end
    rc = qc[S] && !qc[S+1];
    rb = qb[S] && !qb[S+1];
    cl = m_cp || rc;
    bl = m_bp || rb;
    if (cl && bl) begin cl = 0; bl = 0; end
    used = 0;
    m_pulse = 0;
    if (tick) begin
      if (m_phase_on) begin
        if (bl) begin bl = 0; used = 1; end
        else m_pulse = 1;
      end else begin
        if (cl) begin cl = 0; used = 1; m_pulse = 1; end
      end
      if (!used) m_phase_on = !m_phase_on;
    end
    m_cp = cl; m_bp = bl;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (pulse !== m_pulse) begin
      failures++;
      $display("FAIL R2 per-cycle model: pulse=%0b expected=%0b at %0t", pulse, m_pulse, $time);
    end
  endtask

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; tick = 0; creq = 0; breq = 0;
    repeat (3) step();
    check(pulse, 1'b0, "R1 reset output");
    rst = 0;
    tick_idx = 0;
    step();
  endtask

  task automatic run_ticks(input int n);
    repeat (n) begin
      tick = 1; step();
      tick_idx++;
      pulse_at[tick_idx] = pulse;
      tick = 0;
      repeat (3) step();
    end
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  initial begin
    for (int i = 0; i < S + 2; i++) begin qc.push_back(0); qb.push_back(0); end

    // nominal pattern, silent first tick
    do_reset();
    run_ticks(6);
    check(pulse_at[1], 0, "R1 first tick silent");
    check(pulse_at[2], 1, "R2 tick2");
    check(pulse_at[3], 0, "R2 tick3");
    check(pulse_at[6], 1, "R2 tick6");

    // carry
    do_reset();
    run_ticks(2); creq = 1; idle(3); creq = 0; run_ticks(4);
    check(pulse_at[3], 1, "R4 added pulse");
    check(pulse_at[4], 0, "R4 phase held");
    check(pulse_at[5], 1, "R4 resume");

    // borrow
    do_reset();
    run_ticks(2); breq = 1; idle(3); breq = 0; run_ticks(4);
    check(pulse_at[3], 0, "R5 waits silent tick");
    check(pulse_at[4], 0, "R5 deleted pulse");
    check(pulse_at[5], 1, "R5 phase held");

    // same-cycle cancel
    do_reset();
    run_ticks(2); creq = 1; breq = 1; idle(3); creq = 0; breq = 0; run_ticks(4);
    check(pulse_at[3], 0, "R6 cancel tick3");
    check(pulse_at[4], 1, "R6 cancel tick4");
    check(pulse_at[5], 0, "R6 cancel tick5");

    // pending carry meets later borrow, no ticks meanwhile
    do_reset();
    run_ticks(2); creq = 1;
    repeat (3) begin step(); check(pulse, 0, "R8 no tick no pulse"); end
    breq = 1; idle(3); creq = 0; breq = 0; idle(1); run_ticks(4);
    check(pulse_at[3], 0, "R6 staggered tick3");
    check(pulse_at[4], 1, "R6 staggered tick4");

    // merge of two carries
    do_reset();
    run_ticks(2); creq = 1; idle(1); creq = 0; idle(1); creq = 1; idle(3); creq = 0; run_ticks(4);
    check(pulse_at[3], 1, "R7 first carry");
    check(pulse_at[4], 0, "R7 no second carry");
    check(pulse_at[6], 0, "R7 tick6");

    // level held high is one event
    do_reset();
    run_ticks(2); creq = 1; idle(3); run_ticks(6); creq = 0;
    check(pulse_at[3], 1, "R3 held tick3");
    check(pulse_at[4], 0, "R3 held tick4");
    check(pulse_at[6], 0, "R3 held tick6");
    check(pulse_at[7], 1, "R3 held tick7");

    // latency: tick on the sampling edge is too early
    do_reset();
    run_ticks(2); creq = 1; run_ticks(4); creq = 0;
    check(pulse_at[3], 0, "R3 too early");
    check(pulse_at[4], 1, "R3 waits silent slot");
    check(pulse_at[5], 1, "R3 late apply");

    // latency: tick exactly S edges later applies it
    do_reset();
    run_ticks(2); creq = 1; idle(S); run_ticks(2); creq = 0;
    check(pulse_at[3], 1, "R3 exact latency");
    check(pulse_at[4], 0, "R3 exact latency next");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule